// File: doc/BRIEF.md
# I2C Converter Readout Slave

This block is the serial front end of a 16-bit converter. It watches a two-wire bus that uses START and STOP framing. It answers one of two 7-bit device addresses, and a strap input picks which one. It also answers the bus-wide call address when that address is used for writing. Both bus lines are sampled by the system clock, so the block needs no clock of its own from the bus. SDA is driven only through a pull-low enable, and the bus pull-up supplies the high level.

A read hands out the latest 16-bit result, one byte at a time, with the most significant bit first. A write carries one data byte, and its upper four bits hold a guarded configuration request: two guard bits, then a speed flag and a sleep flag. The block does not drive the conversion itself. It raises single-cycle events for a separate sequencer: device selected, full read finished, STOP after a selection, configuration written, and start a new conversion. While the sequencer reports a conversion in progress, the block refuses its own address.

Top module: `adc_readout_i2c`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START that arrives while the bus is already busy behaves exactly like a first START. A STOP releases SDA.
- R2: The address byte carries seven address bits first and the direction bit last (1 = read, 0 = write). The device address is 0010100 when `addr_sel` is 0 and 1010100 when it is 1.
- R3: If the address matches and `conv_busy` is 0, SDA is held low during the ninth clock and `addr_ack` pulses once. If `conv_busy` is 1, SDA stays released and no event pulses.
- R4: SDA driven by the block changes only while SCL is low, never while SCL is high.
- R5: After a read is acknowledged, the bits of `result` go out from bit 15 down to bit 0 in two bytes. SDA is released for the master's acknowledge slot after each byte. When the slot after the second byte ends, `read_done` and `conv_start` each pulse exactly once.
- R6: A STOP after an acknowledged read address, before all 16 bits are read, pulses `conv_start` once. Any STOP after an acknowledged address pulses `stop_seen`.
- R7: After a write is acknowledged, the block acknowledges the data byte. The first four bits are, in order, enable-one, enable-two, speed and sleep. When enable-one is 1 and enable-two is 0, speed goes to `cfg_spd`, sleep goes to `cfg_slp`, and `cfg_wr` pulses.
- R8: Any other pair of enable bits leaves `cfg_spd` and `cfg_slp` unchanged and gives no `cfg_wr` pulse.
- R9: The call address 1110111 is acknowledged with direction bit 0, and its configuration byte is accepted as in R7. With direction bit 1 it is refused.
- R10: Any other address is refused. SDA stays released and no event pulses.
- R11: A low glitch on SCL that lasts a single system-clock sample is ignored.
- R12: A START or STOP in the middle of a byte abandons the transfer. After a START the block takes in a fresh address.
- R13: After reset, SDA is released, `cfg_spd` and `cfg_slp` are 0, and no event is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Strap that picks the device address |
| conv_busy | input | 1 | Conversion in progress, refuse own address |
| result | input | 16 | Conversion result to hand out on a read |
| addr_ack | output | 1 | Pulse: an address was acknowledged |
| read_done | output | 1 | Pulse: all 16 result bits were read |
| stop_seen | output | 1 | Pulse: STOP following an acknowledged address |
| cfg_wr | output | 1 | Pulse: guarded configuration applied |
| conv_start | output | 1 | Pulse: sequencer should begin a conversion |
| cfg_spd | output | 1 | Applied speed flag |
| cfg_slp | output | 1 | Applied sleep flag |

## Verification
The hardest states to reach from the ports are the bus conditions that arrive at awkward moments. These are a STOP in the middle of the data stream, a START in the middle of the address byte, and a one-sample SCL glitch inside a high phase. A legal master never produces them. The bench master model therefore stops early after a chosen number of bits, restarts in the middle of a byte, and forces SCL low for exactly one system clock while SCL is high. After each of these it runs a full, clean read and compares the data, to show that the block recovered. It also sweeps every address with both direction bits and all sixteen configuration nibbles.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RBIT,
    ST_RMACK,
    ST_WBIT,
    ST_WACK,
    ST_SKIP
  } bus_state_t;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/adcif_line_filter.sv
module adcif_line_filter #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  // chain[STAGES-1:0] synchronises; chain[STAGES] keeps the previous sample.
  logic [STAGES:0] chain;
  logic            agree;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], line_i};
  end

  // Accept a new level only after two equal consecutive samples.
  assign agree = (chain[STAGES] == chain[STAGES-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     line_o <= 1'b1;
    else if (agree) line_o <= chain[STAGES-1];
  end

endmodule

// File: rtl/adcif_bus_monitor.sv
module adcif_bus_monitor
  import adcif_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t ev
);

  localparam int LINES = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] raw, filt, filt_q;

  assign raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      adcif_line_filter #(.STAGES(STAGES)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (raw[g]),
        .line_o (filt[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= '1;
    else        filt_q <= filt;
  end

  always_comb begin
    ev.scl_rise = filt[SCL_IX] & ~filt_q[SCL_IX];
    ev.scl_fall = ~filt[SCL_IX] & filt_q[SCL_IX];
    ev.start    = filt[SCL_IX] & filt_q[SCL_IX] & filt_q[SDA_IX] & ~filt[SDA_IX];
    ev.stop     = filt[SCL_IX] & filt_q[SCL_IX] & ~filt_q[SDA_IX] & filt[SDA_IX];
    ev.sda      = filt[SDA_IX];
  end

endmodule

// File: rtl/adcif_protocol.sv
module adcif_protocol
  import adcif_pkg::*;
#(
  parameter int         DATA_W    = 16,
  parameter int         ADDR_W    = 7,
  parameter logic [6:0] ADDR_LOW  = 7'b0010100,
  parameter logic [6:0] ADDR_HIGH = 7'b1010100,
  parameter logic [6:0] ADDR_CALL = 7'b1110111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          ev,
  input  logic              addr_sel,
  input  logic              conv_busy,
  input  logic [DATA_W-1:0] result,
  output logic              sda_oe,
  output logic              addr_ack,
  output logic              read_done,
  output logic              stop_seen,
  output logic              cfg_wr,
  output logic              conv_start,
  output logic              cfg_spd,
  output logic              cfg_slp
);

  localparam int          BYTES     = DATA_W / 8;
  localparam int          BYTE_W    = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int          FRAME_W   = ADDR_W + 1;
  localparam logic [3:0]  BITS_DONE = 4'(FRAME_W);
  localparam logic [3:0]  SLOT_DONE = 4'(FRAME_W + 1);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BYTES - 1);

  bus_state_t          st_q, st_d;
  logic [3:0]          cnt_q, cnt_d;
  logic [FRAME_W-1:0]  sh_q, sh_d;
  logic [DATA_W-1:0]   dsh_q, dsh_d;
  logic [BYTE_W-1:0]   byte_q, byte_d;
  logic                oe_d, rd_pend_q, rd_pend_d, sel_pend_q, sel_pend_d;
  logic                spd_d, slp_d;
  logic                ack_d, done_d, stop_d, cfg_d, conv_d;
  logic [ADDR_W-1:0]   dev_addr;
  logic                own_hit, call_hit, addr_hit, nib_ok;

  assign dev_addr = addr_sel ? ADDR_HIGH : ADDR_LOW;
  assign own_hit  = (sh_q[FRAME_W-1:1] == dev_addr);
  assign call_hit = (sh_q[FRAME_W-1:1] == ADDR_CALL) && !sh_q[0];
  assign addr_hit = (own_hit || call_hit) && !conv_busy;
  // Guard bits: first bit must be 1, second bit must be 0.
  assign nib_ok   = sh_q[FRAME_W-1] && !sh_q[FRAME_W-2];

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    dsh_d      = dsh_q;
    byte_d     = byte_q;
    oe_d       = sda_oe;
    rd_pend_d  = rd_pend_q;
    sel_pend_d = sel_pend_q;
    spd_d      = cfg_spd;
    slp_d      = cfg_slp;
    ack_d      = 1'b0;
    done_d     = 1'b0;
    stop_d     = 1'b0;
    cfg_d      = 1'b0;
    conv_d     = 1'b0;

    if (ev.stop) begin
      st_d       = ST_IDLE;
      oe_d       = 1'b0;
      stop_d     = sel_pend_q;
      conv_d     = rd_pend_q;
      rd_pend_d  = 1'b0;
      sel_pend_d = 1'b0;
    end else if (ev.start) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (ev.scl_rise) begin
            sh_d  = {sh_q[FRAME_W-2:0], ev.sda};
            cnt_d = cnt_q + 4'd1;
          end else if (ev.scl_fall && cnt_q == BITS_DONE) begin
            if (addr_hit) begin
              st_d = ST_AACK;
              oe_d = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (ev.scl_rise) begin
            cnt_d      = SLOT_DONE;
            ack_d      = 1'b1;
            sel_pend_d = 1'b1;
            rd_pend_d  = sh_q[0] | rd_pend_q;
          end else if (ev.scl_fall && cnt_q == SLOT_DONE) begin
            cnt_d = '0;
            if (sh_q[0]) begin
              st_d   = ST_RBIT;
              dsh_d  = result;
              oe_d   = ~result[DATA_W-1];
              byte_d = '0;
            end else begin
              st_d = ST_WBIT;
              oe_d = 1'b0;
            end
          end
        end
        ST_RBIT: begin
          if (ev.scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (ev.scl_fall) begin
            if (cnt_q == BITS_DONE) begin
              st_d = ST_RMACK;
              oe_d = 1'b0;
            end else if (cnt_q != 4'd0) begin
              dsh_d = {dsh_q[DATA_W-2:0], 1'b0};
              oe_d  = ~dsh_q[DATA_W-2];
            end
          end
        end
        ST_RMACK: begin
          if (ev.scl_rise) begin
            cnt_d = SLOT_DONE;
            if (byte_q == LAST_BYTE) begin
              st_d      = ST_SKIP;
              done_d    = 1'b1;
              conv_d    = 1'b1;
              rd_pend_d = 1'b0;
            end else begin
              byte_d = byte_q + BYTE_W'(1);
            end
          end else if (ev.scl_fall && cnt_q == SLOT_DONE) begin
            st_d  = ST_RBIT;
            cnt_d = '0;
            dsh_d = {dsh_q[DATA_W-2:0], 1'b0};
            oe_d  = ~dsh_q[DATA_W-2];
          end
        end
        ST_WBIT: begin
          if (ev.scl_rise) begin
            sh_d  = {sh_q[FRAME_W-2:0], ev.sda};
            cnt_d = cnt_q + 4'd1;
          end else if (ev.scl_fall && cnt_q == BITS_DONE) begin
            st_d = ST_WACK;
            oe_d = 1'b1;
            if (nib_ok) begin
              spd_d = sh_q[FRAME_W-3];
              slp_d = sh_q[FRAME_W-4];
              cfg_d = 1'b1;
            end
          end
        end
        ST_WACK: begin
          if (ev.scl_rise) begin
            cnt_d = SLOT_DONE;
          end else if (ev.scl_fall && cnt_q == SLOT_DONE) begin
            st_d = ST_SKIP;
            oe_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      dsh_q      <= '0;
      byte_q     <= '0;
      sda_oe     <= 1'b0;
      rd_pend_q  <= 1'b0;
      sel_pend_q <= 1'b0;
      cfg_spd    <= 1'b0;
      cfg_slp    <= 1'b0;
      addr_ack   <= 1'b0;
      read_done  <= 1'b0;
      stop_seen  <= 1'b0;
      cfg_wr     <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      dsh_q      <= dsh_d;
      byte_q     <= byte_d;
      sda_oe     <= oe_d;
      rd_pend_q  <= rd_pend_d;
      sel_pend_q <= sel_pend_d;
      cfg_spd    <= spd_d;
      cfg_slp    <= slp_d;
      addr_ack   <= ack_d;
      read_done  <= done_d;
      stop_seen  <= stop_d;
      cfg_wr     <= cfg_d;
      conv_start <= conv_d;
    end
  end

  // R1: a STOP leaves the bus released and the engine idle.
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stop |=> (!sda_oe && st_q == ST_IDLE));

  // R4: the drive enable moves only after a filtered SCL fall or a bus condition.
  a_r4_oe_moves_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(ev.scl_fall || ev.start || ev.stop));

  // R3: a busy converter means no acknowledge drive after the address byte.
  a_r3_busy_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && ev.scl_fall && cnt_q == BITS_DONE && conv_busy
     && !ev.start && !ev.stop) |=> !sda_oe);

  // R5: every conversion request has a completed read or a STOP behind it.
  a_r5_conv_cause: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (read_done || stop_seen));

  // R8: applied settings move only together with a configuration pulse.
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |-> ({cfg_spd, cfg_slp} == $past({cfg_spd, cfg_slp})));

endmodule

// File: rtl/adc_readout_i2c.sv
module adc_readout_i2c
  import adcif_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic              conv_busy,
  input  logic [DATA_W-1:0] result,
  output logic              addr_ack,
  output logic              read_done,
  output logic              stop_seen,
  output logic              cfg_wr,
  output logic              conv_start,
  output logic              cfg_spd,
  output logic              cfg_slp
);

  logic [1:0] rst_pipe;
  logic       rst_core_n;
  bus_evt_t   ev;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  adcif_bus_monitor #(.STAGES(SYNC_STAGES)) u_mon (
    .clk   (clk),
    .rst_n (rst_core_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev)
  );

  adcif_protocol #(.DATA_W(DATA_W)) u_proto (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ev         (ev),
    .addr_sel   (addr_sel),
    .conv_busy  (conv_busy),
    .result     (result),
    .sda_oe     (sda_oe),
    .addr_ack   (addr_ack),
    .read_done  (read_done),
    .stop_seen  (stop_seen),
    .cfg_wr     (cfg_wr),
    .conv_start (conv_start),
    .cfg_spd    (cfg_spd),
    .cfg_slp    (cfg_slp)
  );

endmodule

// File: tb/adc_readout_i2c_test.sv
module adc_readout_i2c_test;

  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, glitch = 1'b0, glitch_arm = 1'b0;
  logic addr_sel = 1'b0, conv_busy = 1'b0;
  logic [15:0] result = 16'hFFFF;
  logic sda_oe, addr_ack, read_done, stop_seen, cfg_wr, conv_start, cfg_spd, cfg_slp;
  logic scl_i, sda_i;

  int n_cmp = 0, n_bad = 0;
  int c_ack = 0, c_done = 0, c_stop = 0, c_cfg = 0, c_conv = 0;
  int oe_viol = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  bit finished = 0;

  assign scl_i = scl_m & ~glitch;
  assign sda_i = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  adc_readout_i2c uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .conv_busy(conv_busy), .result(result),
    .addr_ack(addr_ack), .read_done(read_done), .stop_seen(stop_seen),
    .cfg_wr(cfg_wr), .conv_start(conv_start), .cfg_spd(cfg_spd), .cfg_slp(cfg_slp)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      c_ack  += int'(addr_ack);
      c_done += int'(read_done);
      c_stop += int'(stop_seen);
      c_cfg  += int'(cfg_wr);
      c_conv += int'(conv_start);
      if (scl_m && scl_prev && (sda_oe != oe_prev)) oe_viol++;
    end
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    ticks(H/2); sda_m = b; ticks(H/2); scl_m = 1'b1;
    if (glitch_arm) begin
      ticks(H/2); glitch = 1'b1; ticks(1); glitch = 1'b0; ticks(H/2 - 1);
      glitch_arm = 1'b0;
    end else begin
      ticks(H);
    end
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    ticks(H/2); sda_m = 1'b1; ticks(H/2); scl_m = 1'b1;
    ticks(H/2); b = sda_i; ticks(H/2); scl_m = 1'b0;
  endtask

  task automatic do_start();
    ticks(H/2); sda_m = 1'b1; ticks(H/2); scl_m = 1'b1;
    ticks(H); sda_m = 1'b0; ticks(H); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    ticks(H/2); sda_m = 1'b0; ticks(H/2); scl_m = 1'b1;
    ticks(H); sda_m = 1'b1; ticks(2*H);
  endtask

  task automatic addr_phase(input logic [6:0] a, input logic rw, output logic acked);
    logic b;
    logic [7:0] v;
    v = {a, rw};
    do_start();
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic read_word(output logic [15:0] d);
    logic b;
    for (int by = 0; by < 2; by++) begin
      for (int i = 0; i < 8; i++) begin
        get_bit(b);
        d = {d[14:0], b};
      end
      put_bit(by == 1);
    end
  endtask

  task automatic write_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic full_read(input string req, input logic [6:0] a, input logic [15:0] val);
    logic ak;
    logic [15:0] d;
    int done0, conv0;
    done0 = c_done; conv0 = c_conv;
    result = val;
    addr_phase(a, 1'b1, ak);
    check({req, " read ack"}, ak, 1);
    read_word(d);
    do_stop();
    check({req, " read data"}, d, val);
    check({req, " read_done count"}, c_done - done0, 1);
    check({req, " conv_start count"}, c_conv - conv0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic exp_ack;
    logic e_spd, e_slp;
    logic [15:0] d;
    logic [7:0] v;
    int a0, s0, v0, k0;

    ticks(5);
    rst_n = 1'b1;
    ticks(6);
    // R13: reset state
    check("R13 sda_oe", sda_oe, 0);
    check("R13 cfg", {cfg_spd, cfg_slp}, 0);
    check("R13 events", {addr_ack, read_done, stop_seen, cfg_wr, conv_start}, 0);

    // R2 R3 R6 R9 R10: sweep every address and direction, strap low
    result = 16'hFFFF;
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        exp_ack = (a == 7'h14) || (a == 7'h77 && rw == 0);
        a0 = c_ack; s0 = c_stop; k0 = c_conv;
        addr_phase(7'(a), rw[0], ak);
        do_stop();
        check("R2/R10 ack", ak, exp_ack);
        check("R3 addr_ack count", c_ack - a0, int'(exp_ack));
        check("R6 conv_start on stop", c_conv - k0, int'(exp_ack && rw == 1));
        check("R6 stop_seen", c_stop - s0, int'(exp_ack));
      end
    end
    // R9: call address with read direction refused
    addr_phase(7'h77, 1'b1, ak); do_stop();
    check("R9 call read refused", ak, 0);

    // R2 R5: reads with both straps over computed patterns
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int k = 0; k < 10; k++) begin
        d = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'((k * 16'h2B71) ^ (k << 13));
        full_read("R5", s ? 7'h54 : 7'h14, d);
      end
    end
    addr_sel = 1'b1;
    addr_phase(7'h14, 1'b1, ak); do_stop();
    check("R2 low address refused with strap high", ak, 0);

    // R3: busy refuses own address
    conv_busy = 1'b1;
    a0 = c_ack;
    addr_phase(7'h54, 1'b1, ak); do_stop();
    check("R3 busy nak", ak, 0);
    check("R3 busy no addr_ack", c_ack - a0, 0);
    check("R3 busy sda released", sda_oe, 0);
    conv_busy = 1'b0;

    // R7 R8: all sixteen configuration nibbles
    e_spd = 1'b0; e_slp = 1'b0;
    for (int n = 0; n < 16; n++) begin
      v = {4'(n), 4'h6};
      v0 = c_cfg;
      addr_phase(7'h54, 1'b0, ak);
      check("R7 write addr ack", ak, 1);
      write_byte(v, ak);
      do_stop();
      check("R7 data byte ack", ak, 1);
      if (v[7:6] == 2'b10) begin e_spd = v[5]; e_slp = v[4]; end
      check("R7/R8 cfg_spd", cfg_spd, e_spd);
      check("R7/R8 cfg_slp", cfg_slp, e_slp);
      check("R7/R8 cfg_wr count", c_cfg - v0, int'(v[7:6] == 2'b10));
    end

    // R9: call address write applies the nibble
    addr_phase(7'h77, 1'b0, ak);
    check("R9 call write ack", ak, 1);
    write_byte({4'b1001, 4'h0}, ak);
    do_stop();
    check("R9 call cfg", {cfg_spd, cfg_slp}, 2'b01);

    // R11: one-sample SCL glitch during the address byte
    glitch_arm = 1'b1;
    full_read("R11 glitch", 7'h54, 16'hC35A);

    // R12: STOP after three address bits, then a clean read
    a0 = c_ack;
    do_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); do_stop();
    check("R12 stop abort no ack", c_ack - a0, 0);
    check("R12 stop abort released", sda_oe, 0);
    // R12: START in the middle of an address byte restarts reception
    do_start(); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    addr_phase(7'h54, 1'b1, ak);
    check("R12 restart ack", ak, 1);
    result = 16'h9E07;
    read_word(d); do_stop();
    check("R12 restart data", d, 16'h9E07);

    // R6: STOP in the middle of the data stream
    result = 16'hFFFF;
    v0 = c_done; k0 = c_conv;
    addr_phase(7'h54, 1'b1, ak);
    for (int i = 0; i < 4; i++) get_bit(ak);
    do_stop();
    check("R6 partial read conv_start", c_conv - k0, 1);
    check("R6 partial read no read_done", c_done - v0, 0);

    // R1: write then repeated START into a read
    addr_phase(7'h54, 1'b0, ak);
    write_byte({4'b1010, 4'h0}, ak);
    check("R1 cfg before restart", {cfg_spd, cfg_slp}, 2'b10);
    result = 16'h1234;
    addr_phase(7'h54, 1'b1, ak);
    check("R1 repeated start ack", ak, 1);
    read_word(d); do_stop();
    check("R1 repeated start data", d, 16'h1234);

    // R4: drive changes only during SCL low
    check("R4 oe changes while SCL high", oe_viol, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule